// File: doc/BRIEF.md
# Configurable Four-Register Pipeline Bank

The block holds four data registers that share one input bus. A 2-bit operation code is sampled on every rising clock edge and selects how the bank moves data. Code 0 runs all four registers as one delay line, four stages deep. Codes 1 and 2 each advance one half of the bank as a separate two-deep chain and leave the other half alone. Code 3 freezes the whole bank. The four registers are called R1 to R4 in this note, in chain order.

A separate 2-bit read select picks one register for the output bus through a combinational multiplexer. Reads do not depend on writes: the register on the output can be any register, including one that is being written in the same cycle. An active-low output enable is passed out as a drive flag, `y_oe_o`, next to the data. A pad-level wrapper can turn that pair into a tri-state bus. The core itself has no high-impedance logic.

Top module: `pipe_bank`

## Requirements
- R1: While `rst_ni` is low, all four registers are zero, whatever the operation. Reset acts asynchronously, so the selected register reads zero before the next clock edge.
- R2: With `op_i` = 2'b00, each clock edge does four things at once: R1 takes `d_i`, R2 takes R1, R3 takes R2 and R4 takes R3.
- R3: With `op_i` = 2'b01, R3 takes `d_i` and R4 takes R3 on each edge. R1 and R2 keep their values.
- R4: With `op_i` = 2'b10, R1 takes `d_i` and R2 takes R1 on each edge. R3 and R4 keep their values.
- R5: With `op_i` = 2'b11, all four registers keep their values on every edge, for any number of cycles and any `d_i`.
- R6: `y_o` shows one register, chosen by `sel_i`: 2'b00 gives R4, 2'b01 gives R3, 2'b10 gives R2 and 2'b11 gives R1. The path is combinational, so a register written on an edge shows on `y_o` right after that edge.
- R7: `y_oe_o` equals the inverse of `oe_ni` at all times, with no clock involved. `oe_ni` has no effect on `y_o` or on the registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation code for loading and shifting the bank |
| sel_i | input | 2 | Read select for the output multiplexer |
| oe_ni | input | 1 | Output enable, active low |
| d_i | input | WIDTH | Shared data input |
| y_o | output | WIDTH | Contents of the selected register |
| y_oe_o | output | 1 | High when the output bus should be driven |

## Verification
The register-transfer properties assume that `op_i` and `d_i` are stable at every rising edge. The multiplexer and enable properties assume that `sel_i` and `oe_ni` have settled by the time they are sampled. The bench therefore changes all inputs only on the falling edge. The one exception is reset: `rst_ni` is pulled low in the middle of a cycle, and the bench reads the output before the next edge, which exercises the asynchronous clear. All transfer properties are switched off during reset, so a reset held across an edge never counts as a missed shift. Random sequences cover every operation code, every select value and both enable levels, and the bench compares `y_o` each cycle with its own model of the four registers.

// File: rtl/pbank_pkg.sv
package pbank_pkg;
  localparam int NREGS = 4;
  localparam int SELW  = $clog2(NREGS);

  typedef enum logic [1:0] {
    OP_CHAIN4 = 2'b00,
    OP_LOAD_B = 2'b01,
    OP_LOAD_A = 2'b10,
    OP_FREEZE = 2'b11
  } op_e;

  typedef struct packed {
    logic en;
    logic from_din;
  } stage_ctl_t;
endpackage

// File: rtl/pbank_decode.sv
module pbank_decode
  import pbank_pkg::*;
(
  input  logic [1:0]             op_i,
  output stage_ctl_t [NREGS-1:0] ctl_o
);
  op_e op;
  assign op = op_e'(op_i);

  always_comb begin
    ctl_o = '0;
    ctl_o[0].from_din = 1'b1;
    unique case (op)
      OP_CHAIN4: begin
        for (int k = 0; k < NREGS; k++) ctl_o[k].en = 1'b1;
      end
      OP_LOAD_B: begin
        ctl_o[2].en       = 1'b1;
        ctl_o[2].from_din = 1'b1;
        ctl_o[3].en       = 1'b1;
      end
      OP_LOAD_A: begin
        ctl_o[0].en = 1'b1;
        ctl_o[1].en = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pbank_regs.sv
module pbank_regs
  import pbank_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  stage_ctl_t [NREGS-1:0]      ctl_i,
  input  logic [WIDTH-1:0]            d_i,
  output logic [NREGS-1:0][WIDTH-1:0] regs_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_stage
    logic [WIDTH-1:0] prev, nxt;
    if (g == 0) begin : g_head
      assign prev = d_i;
    end else begin : g_tail
      assign prev = regs_o[g-1];
    end
    assign nxt = ctl_i[g].from_din ? d_i : prev;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          regs_o[g] <= '0;
      else if (ctl_i[g].en) regs_o[g] <= nxt;
    end
  end
endmodule

// File: rtl/pbank_rdmux.sv
module pbank_rdmux
  import pbank_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [SELW-1:0]             sel_i,
  input  logic [NREGS-1:0][WIDTH-1:0] regs_i,
  output logic [WIDTH-1:0]            y_o
);
  logic [SELW-1:0] idx;
  // select counts down from the chain tail
  assign idx = SELW'(NREGS - 1) - sel_i;
  assign y_o = regs_i[idx];
endmodule

// File: rtl/pipe_bank.sv
module pipe_bank
  import pbank_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       op_i,
  input  logic [1:0]       sel_i,
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] y_o,
  output logic             y_oe_o
);
  stage_ctl_t [NREGS-1:0]      ctl;
  logic [NREGS-1:0][WIDTH-1:0] regs_q;

  pbank_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  pbank_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl),
    .d_i    (d_i),
    .regs_o (regs_q)
  );

  pbank_rdmux #(.WIDTH(WIDTH)) u_mux (
    .sel_i  (sel_i),
    .regs_i (regs_q),
    .y_o    (y_o)
  );

  assign y_oe_o = ~oe_ni;
endmodule

// File: rtl/pipe_bank_chk.sv
module pipe_bank_chk #(
  parameter int WIDTH = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [1:0]            op_i,
  input logic [1:0]            sel_i,
  input logic                  oe_ni,
  input logic [WIDTH-1:0]      d_i,
  input logic [WIDTH-1:0]      y_o,
  input logic                  y_oe_o,
  input logic [3:0][WIDTH-1:0] regs_i
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (regs_i == '0));

  // R2
  chain4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b00 |=> regs_i[0] == $past(d_i) && regs_i[1] == $past(regs_i[0])
                   && regs_i[2] == $past(regs_i[1]) && regs_i[3] == $past(regs_i[2]));

  // R3
  load_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b01 |=> $stable(regs_i[0]) && $stable(regs_i[1])
                   && regs_i[2] == $past(d_i) && regs_i[3] == $past(regs_i[2]));

  // R4
  load_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b10 |=> regs_i[0] == $past(d_i) && regs_i[1] == $past(regs_i[0])
                   && $stable(regs_i[2]) && $stable(regs_i[3]));

  // R5
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b11 |=> $stable(regs_i));

  // R6
  read_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b00 && y_o == regs_i[3]) || (sel_i == 2'b01 && y_o == regs_i[2])
    || (sel_i == 2'b10 && y_o == regs_i[1]) || (sel_i == 2'b11 && y_o == regs_i[0]));

  // R7
  drive_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_oe_o != oe_ni);
endmodule

bind pipe_bank pipe_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .op_i   (op_i),
  .sel_i  (sel_i),
  .oe_ni  (oe_ni),
  .d_i    (d_i),
  .y_o    (y_o),
  .y_oe_o (y_oe_o),
  .regs_i (regs_q)
);

// File: tb/pipe_bank_test.sv
`timescale 1ns/1ps
module pipe_bank_test;
  localparam int W = 16;
  localparam int NV = 12;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   op_i = 2'b11;
  logic [1:0]   sel_i = 2'b00;
  logic         oe_ni = 1'b0;
  logic [W-1:0] d_i = '0;
  logic [W-1:0] y_o;
  logic         y_oe_o;

  int total = 0;
  int bad = 0;
  logic [W-1:0] m [4];

  always #2 clk_i = ~clk_i;

  pipe_bank #(.WIDTH(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .sel_i(sel_i),
    .oe_ni(oe_ni), .d_i(d_i), .y_o(y_o), .y_oe_o(y_oe_o)
  );

  // {op, sel, d, expected y after the edge}
  localparam logic [35:0] VEC [NV] = '{
    {2'b00, 2'b11, 16'h1111, 16'h1111},  // R2 R6
    {2'b00, 2'b10, 16'h2222, 16'h1111},  // R2
    {2'b00, 2'b01, 16'h3333, 16'h1111},  // R2
    {2'b00, 2'b00, 16'h4444, 16'h1111},  // R2
    {2'b01, 2'b01, 16'haaaa, 16'haaaa},  // R3
    {2'b01, 2'b00, 16'hbbbb, 16'haaaa},  // R3
    {2'b10, 2'b10, 16'hcccc, 16'h4444},  // R4
    {2'b10, 2'b11, 16'hdddd, 16'hdddd},  // R4
    {2'b11, 2'b00, 16'heeee, 16'haaaa},  // R5
    {2'b11, 2'b01, 16'hffff, 16'hbbbb},  // R5
    {2'b00, 2'b00, 16'h0123, 16'hbbbb},  // R2
    {2'b11, 2'b10, 16'h0000, 16'hdddd}   // R5
  };

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mread(logic [1:0] s);
    return m[3 - int'(s)];
  endfunction

  task automatic model_step(logic [1:0] op, logic [W-1:0] d);
    case (op)
      2'b00: begin m[3] = m[2]; m[2] = m[1]; m[1] = m[0]; m[0] = d; end
      2'b01: begin m[3] = m[2]; m[2] = d; end
      2'b10: begin m[1] = m[0]; m[0] = d; end
      default: ;
    endcase
  endtask

  task automatic step(logic [1:0] op, logic [1:0] s, logic [W-1:0] d, logic oe);
    @(negedge clk_i);
    op_i = op; sel_i = s; d_i = d; oe_ni = oe;
    @(posedge clk_i);
    model_step(op, d);
    #1;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) m[k] = '0;
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state on every select
    for (int s = 0; s < 4; s++) begin
      sel_i = 2'(s);
      #0.1;
      check("R1 reset", y_o, '0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // vector table: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][35:34], VEC[v][33:32], VEC[v][31:16], 1'b0);
      check("R2-chain/R3/R4/R5 table", y_o, VEC[v][15:0]);
      check("R6 table model", y_o, mread(VEC[v][33:32]));
    end

    // R7 enable flag, data path unaffected
    @(negedge clk_i);
    oe_ni = 1'b1; sel_i = 2'b11;
    #0.5;
    total++;
    if (y_oe_o !== 1'b0) begin
      bad++;
      $display("FAIL R7: actual=%b expected=0", y_oe_o);
    end
    check("R7 data kept", y_o, mread(2'b11));
    oe_ni = 1'b0;
    #0.5;
    total++;
    if (y_oe_o !== 1'b1) begin
      bad++;
      $display("FAIL R7: actual=%b expected=1", y_oe_o);
    end

    // random mix of all ops, selects and enables
    for (int i = 0; i < 3000; i++) begin
      logic oe;
      oe = 1'($urandom);
      step(2'($urandom), 2'($urandom), W'($urandom), oe);
      check("R6 random", y_o, mread(sel_i));
      total++;
      if (y_oe_o !== ~oe) begin
        bad++;
        $display("FAIL R7 random: actual=%b expected=%b", y_oe_o, ~oe);
      end
    end

    // R5 long freeze, all registers observed through the mux
    for (int i = 0; i < 400; i++) begin
      step(2'b11, 2'(i), W'($urandom), 1'b0);
      check("R5 long hold", y_o, mread(sel_i));
    end

    // R3 then R4: each half must leave the other untouched
    for (int i = 0; i < 6; i++) begin
      step(2'b01, 2'b11, W'(16'h5000 + i), 1'b0);
      check("R3 R1 untouched", y_o, mread(2'b11));
    end
    for (int i = 0; i < 6; i++) begin
      step(2'b10, 2'b00, W'(16'h6000 + i), 1'b0);
      check("R4 R4 untouched", y_o, mread(2'b00));
    end

    // R1 asynchronous clear in mid-cycle
    step(2'b00, 2'b11, 16'h7777, 1'b0);
    @(negedge clk_i);
    op_i = 2'b11;
    rst_ni = 1'b0;
    for (int k = 0; k < 4; k++) m[k] = '0;
    for (int s = 0; s < 4; s++) begin
      sel_i = 2'(s);
      #0.1;
      check("R1 async clear", y_o, '0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(2'b00, 2'b11, 16'h9abc, 1'b0);
    check("R1 resume after reset", y_o, 16'h9abc);
    sel_i = 2'b10;
    #0.2;
    check("R1 R2 still zero", y_o, '0);

    finish_run();
  end
endmodule